// File: doc/BRIEF.md
# Stepped Device Bus Bridge

This block links a processor's internal word buses to an external device bus. The control unit loads a command with a single trigger pulse: one mode bit picks a write or a read, and a three-bit device number picks one of eight devices. A step counter then runs the command through five one-cycle steps. The block takes the address first and then, for a write, the data word, both from one shared inbound word bus. The external address and data buses are modelled as a value plus an output-enable. A read returns its word to the control side on a return bus that also has its own enable.

The block also carries the interrupt traffic. While a command is running, the block drives the shared interrupt line. While it is idle, a device may raise that line, and the internal interrupt output follows it. When a device raises the interrupt and transmit lines together while the block is idle, the block takes the data bus as an interrupt code and parks. While parked, the internal interrupt output is held high and a trigger reads the code out instead of starting a command. Only reset leaves the parked state.

Neither stream has back-pressure. The inbound bus is sampled in a fixed step and the return bus shows a word for exactly one cycle. The control unit must present each word in the right cycle and take the returned word when the return enable is high.

Top module: `xbus_bridge`

## Requirements
- R1: When `trigger` is high in an idle, unparked cycle, the next cycle has `busy_o` high, the step counter in its first step, and `mode_o` equal to the sampled `mode` (0 = write, 1 = read).
- R2: During steps one to four, `dev_sel_o` has exactly bit `dev` set, taking `dev` as it was sampled with the trigger. In every other cycle `dev_sel_o` is zero.
- R3: A write takes the address from `send_i` in step one and the data word in step two. In steps three and four `addr_oe`, `data_oe` and `tx_drive` are high, and `addr_o` and `data_o` carry the two words.
- R4: A read takes the address from `send_i` in step one and drives `addr_oe` with it in steps two and three. It captures `data_i` at the end of step three and shows that word on `ret_o` with `ret_oe` high in step four.
- R5: Step five drives nothing. After it the block is idle, so a trigger in the very next cycle (six cycles after the first trigger) is accepted.
- R6: `irq_drive` is high exactly while `busy_o` is high. Outside the parked state, `irq_o` is low while busy and equals `irq_i` while idle.
- R7: In an idle, unparked cycle with `irq_i` and `tx_i` high and `trigger` low, the block stores `data_i` as the interrupt code and parks. While parked, `irq_o` is high whatever `irq_i` does.
- R8: While parked, a cycle with `trigger` high makes the next cycle show the stored code on `ret_o` with `ret_oe` high, for one cycle per trigger cycle. No command starts.
- R9: Only `rst` ends the parked state. After reset, `irq_o` follows `irq_i` again.
- R10: `rst` high at a clock edge returns the block to idle from any step. All enables and selects are then low.
- R11: A trigger while busy, including in step five, is ignored. The running command keeps its timing, device and mode.
- R12: `ret_oe` is high only in read step four or in a code readout, and never in the same cycle as `data_oe`.
- R13: If a trigger and an interrupt code arrive in the same idle cycle, the trigger wins and no code is stored. Interrupt and transmit seen while busy are not taken as a code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trigger | input | 1 | Starts a command, or reads out the code while parked |
| mode | input | 1 | 0 = write to device, 1 = read from device |
| dev | input | 3 | Target device number |
| send_i | input | 16 | Inbound word bus (address, then data) |
| ret_o | output | 16 | Return word, zero when not enabled |
| ret_oe | output | 1 | Return word valid this cycle |
| busy_o | output | 1 | A command is running |
| irq_o | output | 1 | Internal interrupt to the control unit |
| addr_o | output | 16 | External address value, zero when not enabled |
| addr_oe | output | 1 | External address drive enable |
| data_o | output | 16 | External data value, zero when not enabled |
| data_oe | output | 1 | External data drive enable |
| data_i | input | 16 | Resolved external data bus |
| dev_sel_o | output | 8 | One-hot device selects |
| mode_o | output | 1 | Latched mode while selects are active, else 0 |
| tx_drive | output | 1 | Block pulls the transmit line high |
| tx_i | input | 1 | Resolved transmit line |
| irq_drive | output | 1 | Block pulls the interrupt line high |
| irq_i | input | 1 | Resolved interrupt line |

## Verification
The embedded properties check the rules that hold on every cycle. The select vector is one-hot while a command runs and zero otherwise. The data drive never appears without the address drive and the transmit pull, and it never overlaps the return enable. The interrupt line is driven whenever the block is busy, and the parked state keeps the internal interrupt high. A running sequence advances one step per cycle, and a read returns the word it sampled one cycle earlier. Other behaviours can only be shown by the bench scenarios against its cycle model: the exact order in which the two inbound words are taken, that a trigger in mid-command or in step five is lost, that a trigger beats a simultaneous interrupt code, and that reset ends both a command in mid-flight and the parked state.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int STEP_W = 3;
  typedef logic [STEP_W-1:0] step_t;

  localparam step_t STEP_NONE = 3'd0;
  localparam step_t STEP_ADDR = 3'd1;
  localparam step_t STEP_DATA = 3'd2;
  localparam step_t STEP_XFER = 3'd3;
  localparam step_t STEP_HOLD = 3'd4;
  localparam step_t STEP_DONE = 3'd5;

  typedef enum logic {
    XF_WRITE = 1'b0,
    XF_READ  = 1'b1
  } xfer_e;

endpackage

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
  import xbus_pkg::*;
#(
  parameter int DEV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trigger,
  input  logic             mode,
  input  logic [DEV_W-1:0] dev,
  input  logic             irq_i,
  input  logic             tx_i,
  output logic             busy,
  output step_t            step,
  output xfer_e            mode_q,
  output logic [DEV_W-1:0] dev_q,
  output logic             park,
  output logic             show,
  output logic             code_take
);

  // code capture only from a quiet, idle bus; a trigger in the same cycle wins
  assign code_take = !busy && !park && !trigger && irq_i && tx_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      step   <= STEP_NONE;
      mode_q <= XF_WRITE;
      dev_q  <= '0;
      park   <= 1'b0;
      show   <= 1'b0;
    end else begin
      show <= park && trigger;
      if (busy) begin
        if (step == STEP_DONE) begin
          busy   <= 1'b0;
          step   <= STEP_NONE;
          mode_q <= XF_WRITE;
          dev_q  <= '0;
        end else begin
          step <= step + step_t'(1);
        end
      end else if (!park) begin
        if (trigger) begin
          busy   <= 1'b1;
          step   <= STEP_ADDR;
          mode_q <= xfer_e'(mode);
          dev_q  <= dev;
        end else if (code_take) begin
          park <= 1'b1;
        end
      end
    end
  end

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (busy && step != STEP_DONE) |=> (busy && step == $past(step) + step_t'(1))); // R11
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (busy && step == STEP_DONE) |=> !busy); // R5
  AST_PARK_STICKY: assert property (@(posedge clk) disable iff (rst)
    park |=> park); // R9
  AST_PARK_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    park |-> !busy); // R8

endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] send_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ld_addr,
  input  logic              ld_wdata,
  input  logic              ld_rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (ld_addr)  addr_q  <= ADDR_W'(send_i);
      if (ld_wdata) wdata_q <= send_i;
      if (ld_rdata) rdata_q <= data_i;
    end
  end

endmodule

// File: rtl/xbus_sel_decode.sv
module xbus_sel_decode #(
  parameter int N_DEV = 8,
  parameter int DEV_W = 3
) (
  input  logic             en,
  input  logic [DEV_W-1:0] dev,
  output logic [N_DEV-1:0] sel
);

  for (genvar g = 0; g < N_DEV; g++) begin : g_line
    assign sel[g] = en && (dev == DEV_W'(g));
  end

endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int N_DEV  = 8,
  parameter int DEV_W  = $clog2(N_DEV)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trigger,
  input  logic              mode,
  input  logic [DEV_W-1:0]  dev,
  input  logic [DATA_W-1:0] send_i,
  output logic [DATA_W-1:0] ret_o,
  output logic              ret_oe,
  output logic              busy_o,
  output logic              irq_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  input  logic [DATA_W-1:0] data_i,
  output logic [N_DEV-1:0]  dev_sel_o,
  output logic              mode_o,
  output logic              tx_drive,
  input  logic              tx_i,
  output logic              irq_drive,
  input  logic              irq_i
);

  logic             busy, park, show, code_take;
  step_t            step;
  xfer_e            mode_q;
  logic [DEV_W-1:0] dev_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic is_rd, sel_en, ld_addr, ld_wdata, ld_rdata;

  xbus_sequencer #(.DEV_W(DEV_W)) i_seq (
    .clk(clk), .rst(rst), .trigger(trigger), .mode(mode), .dev(dev),
    .irq_i(irq_i), .tx_i(tx_i), .busy(busy), .step(step), .mode_q(mode_q),
    .dev_q(dev_q), .park(park), .show(show), .code_take(code_take)
  );

  // step decode
  assign is_rd    = (mode_q == XF_READ);
  assign sel_en   = busy && (step != STEP_DONE);
  assign ld_addr  = busy && (step == STEP_ADDR);
  assign ld_wdata = busy && !is_rd && (step == STEP_DATA);
  assign ld_rdata = (busy && is_rd && (step == STEP_XFER)) || code_take;

  xbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst(rst), .send_i(send_i), .data_i(data_i),
    .ld_addr(ld_addr), .ld_wdata(ld_wdata), .ld_rdata(ld_rdata),
    .addr_q(addr_q), .wdata_q(wdata_q), .rdata_q(rdata_q)
  );

  xbus_sel_decode #(.N_DEV(N_DEV), .DEV_W(DEV_W)) i_dec (
    .en(sel_en), .dev(dev_q), .sel(dev_sel_o)
  );

  always_comb begin
    addr_oe = 1'b0;
    data_oe = 1'b0;
    if (busy) begin
      if (is_rd) addr_oe = (step == STEP_DATA) || (step == STEP_XFER);
      else begin
        addr_oe = (step == STEP_XFER) || (step == STEP_HOLD);
        data_oe = addr_oe;
      end
    end
  end

  assign tx_drive  = data_oe;
  assign addr_o    = addr_oe ? addr_q : '0;
  assign data_o    = data_oe ? wdata_q : '0;
  assign ret_oe    = (busy && is_rd && (step == STEP_HOLD)) || show;
  assign ret_o     = ret_oe ? rdata_q : '0;
  assign busy_o    = busy;
  assign irq_drive = busy;
  assign irq_o     = park || (!busy && irq_i);
  assign mode_o    = sel_en && is_rd;

  AST_SEL_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    (dev_sel_o != '0) |-> (busy_o && $countones(dev_sel_o) == 1)); // R2
  AST_WRITE_DRIVE_PAIRED: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (addr_oe && tx_drive && dev_sel_o != '0)); // R3
  AST_READ_RETURNS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && step == STEP_XFER) |=> (ret_oe && ret_o == $past(data_i))); // R4
  AST_BUSY_HOLDS_IRQ: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (irq_drive && !irq_o)); // R6
  AST_PARK_IRQ_HIGH: assert property (@(posedge clk) disable iff (rst)
    park |-> irq_o); // R7
  AST_RET_DATA_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ret_oe && data_oe)); // R12

endmodule

// File: tb/test_xbus_bridge.sv
`timescale 1ns/1ps
module test_xbus_bridge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trigger = 1'b0, mode = 1'b0;
  logic [2:0]  dev = '0;
  logic [15:0] send_i = '0, data_i = '0;
  logic        tx_i = 1'b0, irq_i = 1'b0;
  logic [15:0] ret_o, addr_o, data_o;
  logic        ret_oe, busy_o, irq_o, addr_oe, data_oe, mode_o, tx_drive, irq_drive;
  logic [7:0]  dev_sel_o;

  always #4 clk = ~clk; // 125 MHz

  xbus_bridge i_xbus_bridge (
    .clk(clk), .rst(rst), .trigger(trigger), .mode(mode), .dev(dev),
    .send_i(send_i), .ret_o(ret_o), .ret_oe(ret_oe), .busy_o(busy_o),
    .irq_o(irq_o), .addr_o(addr_o), .addr_oe(addr_oe), .data_o(data_o),
    .data_oe(data_oe), .data_i(data_i), .dev_sel_o(dev_sel_o), .mode_o(mode_o),
    .tx_drive(tx_drive), .tx_i(tx_i), .irq_drive(irq_drive), .irq_i(irq_i)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit started = 0;

  // behavioural reference model
  bit m_busy, m_mode, m_park, m_show;
  int m_step, m_dev;
  logic [15:0] m_addr, m_wdata, m_rdata;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_busy = 0; m_step = 0; m_park = 0; m_show = 0; m_mode = 0; m_dev = 0;
    end else begin
      bit nshow;
      nshow = m_park && trigger;
      if (m_busy) begin
        if (m_step == 1) m_addr = send_i;
        if (m_step == 2 && !m_mode) m_wdata = send_i;
        if (m_step == 3 && m_mode) m_rdata = data_i;
        if (m_step == 5) begin m_busy = 0; m_step = 0; m_mode = 0; m_dev = 0; end
        else m_step++;
      end else if (!m_park) begin
        if (trigger) begin m_busy = 1; m_step = 1; m_mode = mode; m_dev = int'(dev); end
        else if (irq_i && tx_i) begin m_rdata = data_i; m_park = 1; end
      end
      m_show = nshow;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      bit sel_on, aoe, doe, roe;
      sel_on = m_busy && m_step >= 1 && m_step <= 4;
      aoe = m_busy && (m_mode ? (m_step == 2 || m_step == 3) : (m_step == 3 || m_step == 4));
      doe = m_busy && !m_mode && (m_step == 3 || m_step == 4);
      roe = (m_busy && m_mode && m_step == 4) || m_show;
      chk("R1 R5 R10 R11", "busy", 32'(busy_o), 32'(m_busy));
      chk("R1", "mode_o", 32'(mode_o), 32'(sel_on && m_mode));
      chk("R2", "dev_sel", 32'(dev_sel_o), sel_on ? 32'(1) << m_dev : 32'd0);
      chk("R3 R4", "addr_oe", 32'(addr_oe), 32'(aoe));
      chk("R3 R4", "addr_o", 32'(addr_o), aoe ? 32'(m_addr) : 32'd0);
      chk("R3", "data_oe", 32'(data_oe), 32'(doe));
      chk("R3", "data_o", 32'(data_o), doe ? 32'(m_wdata) : 32'd0);
      chk("R3", "tx_drive", 32'(tx_drive), 32'(doe));
      chk("R4 R8 R12", "ret_oe", 32'(ret_oe), 32'(roe));
      chk("R4 R8", "ret_o", 32'(ret_o), roe ? 32'(m_rdata) : 32'd0);
      chk("R6", "irq_drive", 32'(irq_drive), 32'(m_busy));
      chk("R6 R7 R9 R13", "irq_o", 32'(irq_o), 32'(m_park || (!m_busy && irq_i)));
      chk("R12", "ret_with_data", 32'(ret_oe && data_oe), 32'd0);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic start(input bit md, input logic [2:0] d);
    trigger = 1; mode = md; dev = d; tick(); trigger = 0; mode = 0; dev = 0;
  endtask

  task automatic do_write(input logic [2:0] d, input logic [15:0] a, input logic [15:0] w);
    start(0, d);
    send_i = a; tick();
    send_i = w; tick();
    send_i = 0; repeat (3) tick();
  endtask

  task automatic do_read(input logic [2:0] d, input logic [15:0] a, input logic [15:0] w);
    start(1, d);
    send_i = a; tick();
    send_i = 0; tick();
    data_i = w; tx_i = 1; tick();
    data_i = 0; tx_i = 0; repeat (2) tick();
  endtask

  initial begin
    repeat (2) tick();
    rst = 0; tick();                       // R10 reset state observed
    do_write(3'd3, 16'h1234, 16'hBEEF);    // R3
    do_read(3'd5, 16'h0040, 16'hC0DE);     // R4, back-to-back R5
    do_write(3'd7, 16'hFFFF, 16'h0001);    // R2 top device
    do_read(3'd0, 16'h0000, 16'hA5A5);     // R2 bottom device
    // R11: trigger mid-command and in step five is lost
    start(0, 3'd2);
    send_i = 16'h0101; tick();
    send_i = 16'h0202; trigger = 1; mode = 1; dev = 3'd6; tick();
    trigger = 0; mode = 0; dev = 0; send_i = 0; tick(); tick();
    trigger = 1; mode = 1; dev = 3'd4; tick();   // step five
    trigger = 0; mode = 0; dev = 0; tick();
    // R6: internal interrupt follows the line when idle
    irq_i = 1; tick(); tick(); irq_i = 0; tick();
    // R13: device interrupt and transmit while busy give no code
    start(0, 3'd1);
    irq_i = 1; tx_i = 1; data_i = 16'h7777; send_i = 16'h0010; tick();
    irq_i = 0; tx_i = 0; data_i = 0; send_i = 16'h0020; tick();
    send_i = 0; repeat (3) tick();
    // R13: trigger beats a simultaneous code
    trigger = 1; mode = 1; dev = 3'd2; irq_i = 1; tx_i = 1; data_i = 16'h9999; tick();
    trigger = 0; mode = 0; dev = 0; irq_i = 0; tx_i = 0; data_i = 0;
    send_i = 16'h0033; tick(); send_i = 0; tick();
    data_i = 16'h4242; tx_i = 1; tick(); data_i = 0; tx_i = 0; repeat (2) tick();
    // R7: code capture and park
    irq_i = 1; tx_i = 1; data_i = 16'h5A3C; tick();
    irq_i = 0; tx_i = 0; data_i = 0; tick(); tick();
    // R8: readout instead of command, twice
    trigger = 1; mode = 0; dev = 3'd3; tick(); trigger = 0; dev = 0; tick(); tick();
    trigger = 1; tick(); tick(); trigger = 0; tick();
    // R9: only reset leaves park
    rst = 1; tick(); rst = 0; tick();
    irq_i = 1; tick(); irq_i = 0; tick();
    // R10: reset in write step three
    start(0, 3'd6);
    send_i = 16'h0ABC; tick(); send_i = 16'h0DEF; tick(); send_i = 0;
    rst = 1; tick(); rst = 0; tick(); tick();
    do_read(3'd4, 16'h0F0F, 16'h3C3C);     // works after reset
    tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule